// File: doc/BRIEF.md
# Operand Pointer Registers

This block keeps the register pointers of a small accumulator-style processor. Rather than carrying register fields in every instruction, the processor issues short prefix instructions ahead of the work: one prefix family names the active general-purpose register, and a second family fills a routing register that names the second operand for ALU and memory-access instructions. Once written, these pointers stay put and apply to every later instruction until another prefix replaces them. The pointers only address registers. They never hold computed results.

Two linked multiplexers turn the stored pointers into operand data. Both read from the same flattened register-file image, which has 16 registers of 8 bits. The destination multiplexer follows the primary pointer. The source multiplexer follows the routing pointer, which is a group number plus a member within that group, so any register in any group can be chosen. The register-file read path is combinational, so the data follows a pointer change in the same cycle. The instruction decode strobe and the 8-bit opcode come from the processor's decoder.

Top module: `opp_top`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `dst_idx` and `src_idx` are both 0.
- R2: An opcode whose upper nibble is 0xF, taken while `instr_valid` is high, loads its low nibble into `dst_idx` from the next clock edge on; `src_idx` keeps its value.
- R3: An opcode whose upper nibble is 0xE, taken while `instr_valid` is high, loads the routing register: bits [3:2] are the group and bits [1:0] the member, so from the next edge `src_idx` = group*4 + member. `dst_idx` keeps its value.
- R4: Any opcode from 0x00 to 0xDF, taken while `instr_valid` is high, leaves both `dst_idx` and `src_idx` unchanged.
- R5: While `instr_valid` is low, no opcode value changes either pointer, including opcodes from 0xE0 to 0xFF.
- R6: `dst_data` equals register `dst_idx` of `rf_rdata`, where register k occupies bits [8k+7:8k], in the same cycle.
- R7: `src_data` equals register `src_idx` of `rf_rdata` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| instr_valid | input | 1 | Decoded instruction strobe for the current opcode |
| opcode | input | 8 | Instruction code |
| rf_rdata | input | 128 | Register-file image, register k in bits [8k+7:8k] |
| dst_idx | output | 4 | Primary (destination) register pointer |
| src_idx | output | 4 | Routing (source) register pointer |
| dst_data | output | 8 | Data of the register named by `dst_idx` |
| src_data | output | 8 | Data of the register named by `src_idx` |

## Verification
The assertions assume that `instr_valid` and `opcode` are stable around the rising clock edge. They also assume that `rf_rdata` only changes between edges, so the combinational read is settled when it is sampled. The bench changes every input on the falling edge, and it replaces the whole register-file image with fresh random bytes on each step, so a multiplexer that selects the wrong word shows up at once. Opcodes from all three classes are sent with the strobe both high and low. This includes the edge codes 0xDF, 0xE0, 0xEF, 0xF0 and 0xFF, followed by a long random run.

// File: rtl/opp_pkg.sv
package opp_pkg;
    parameter int unsigned NUM_REGS = 16;
    parameter int unsigned DATA_W   = 8;
    parameter int unsigned OPC_W    = 8;
    parameter int unsigned GRP_CNT  = 4;

    localparam int unsigned IDX_W  = $clog2(NUM_REGS);
    localparam int unsigned GRP_W  = $clog2(GRP_CNT);
    localparam int unsigned MEM_W  = IDX_W - GRP_W;
    localparam int unsigned TAG_W  = OPC_W - IDX_W;
    localparam int unsigned FLAT_W = NUM_REGS * DATA_W;

    localparam logic [TAG_W-1:0] TAG_SELECT = '1;
    localparam logic [TAG_W-1:0] TAG_ROUTE  = TAG_SELECT - 1'b1;

    typedef enum logic [1:0] {
        OPK_NONE   = 2'd0,
        OPK_SELECT = 2'd1,
        OPK_ROUTE  = 2'd2
    } op_kind_e;

    typedef struct packed {
        logic [IDX_W-1:0] pri;
        logic [GRP_W-1:0] grp;
        logic [MEM_W-1:0] mbr;
    } ptr_state_t;
endpackage

// File: rtl/opp_decode.sv
module opp_decode
    import opp_pkg::*;
(
    input  logic             instr_valid,
    input  logic [OPC_W-1:0] opcode,
    output op_kind_e         kind,
    output logic [IDX_W-1:0] payload
);
    logic [TAG_W-1:0] tag;

    always_comb begin
        tag     = opcode[OPC_W-1:IDX_W];
        payload = opcode[IDX_W-1:0];
        kind    = OPK_NONE;
        if (instr_valid) begin
            if (tag == TAG_SELECT) begin
                kind = OPK_SELECT;
            end else if (tag == TAG_ROUTE) begin
                kind = OPK_ROUTE;
            end
        end
    end
endmodule

// File: rtl/opp_ptr_regs.sv
module opp_ptr_regs
    import opp_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  op_kind_e         kind,
    input  logic [IDX_W-1:0] payload,
    output logic [IDX_W-1:0] pri_idx,
    output logic [IDX_W-1:0] sec_idx
);
    ptr_state_t state_d;
    ptr_state_t state_q;

    always_comb begin
        state_d = state_q;
        unique case (kind)
            OPK_SELECT: state_d.pri = payload;
            OPK_ROUTE: begin
                state_d.grp = payload[IDX_W-1:MEM_W];
                state_d.mbr = payload[MEM_W-1:0];
            end
            default: state_d = state_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign pri_idx = state_q.pri;
    assign sec_idx = {state_q.grp, state_q.mbr};
endmodule

// File: rtl/opp_operand_mux.sv
module opp_operand_mux #(
    parameter int unsigned N     = 16,
    parameter int unsigned W     = 8,
    localparam int unsigned SEL_W = $clog2(N)
) (
    input  logic [N*W-1:0]   flat,
    input  logic [SEL_W-1:0] sel,
    output logic [W-1:0]     dout
);
    logic [W-1:0] words [N];

    for (genvar k = 0; k < N; k++) begin : g_split
        assign words[k] = flat[k*W +: W];
    end

    always_comb begin
        dout = words[sel];
    end
endmodule

// File: rtl/opp_top.sv
module opp_top
    import opp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              instr_valid,
    input  logic [OPC_W-1:0]  opcode,
    input  logic [FLAT_W-1:0] rf_rdata,
    output logic [IDX_W-1:0]  dst_idx,
    output logic [IDX_W-1:0]  src_idx,
    output logic [DATA_W-1:0] dst_data,
    output logic [DATA_W-1:0] src_data
);
    localparam int unsigned PORTS = 2;

    op_kind_e          kind;
    logic [IDX_W-1:0]  payload;
    logic [IDX_W-1:0]  sel   [PORTS];
    logic [DATA_W-1:0] rdata [PORTS];

    opp_decode u_dec (
        .instr_valid (instr_valid),
        .opcode      (opcode),
        .kind        (kind),
        .payload     (payload)
    );

    opp_ptr_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .kind    (kind),
        .payload (payload),
        .pri_idx (dst_idx),
        .sec_idx (src_idx)
    );

    assign sel[0] = dst_idx;
    assign sel[1] = src_idx;

    for (genvar p = 0; p < PORTS; p++) begin : g_port
        opp_operand_mux #(
            .N (NUM_REGS),
            .W (DATA_W)
        ) u_mux (
            .flat (rf_rdata),
            .sel  (sel[p]),
            .dout (rdata[p])
        );
    end

    assign dst_data = rdata[0];
    assign src_data = rdata[1];
endmodule

// File: rtl/opp_checker.sv
module opp_checker
    import opp_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              instr_valid,
    input logic [OPC_W-1:0]  opcode,
    input logic [FLAT_W-1:0] rf_rdata,
    input logic [IDX_W-1:0]  dst_idx,
    input logic [IDX_W-1:0]  src_idx,
    input logic [DATA_W-1:0] dst_data,
    input logic [DATA_W-1:0] src_data
);
    logic sel_op;
    logic rte_op;
    assign sel_op = instr_valid && (opcode[OPC_W-1:IDX_W] == TAG_SELECT);
    assign rte_op = instr_valid && (opcode[OPC_W-1:IDX_W] == TAG_ROUTE);

    always @(negedge clk) begin
        if (!rst_n) begin
            AST_RESET_CLEAR: assert (dst_idx == '0 && src_idx == '0); // R1
        end
    end

    AST_SELECT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        sel_op |=> dst_idx == $past(opcode[IDX_W-1:0])); // R2
    AST_SELECT_KEEPS_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        sel_op |=> $stable(src_idx)); // R2
    AST_ROUTE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        rte_op |=> src_idx == $past(opcode[IDX_W-1:0])); // R3
    AST_ROUTE_KEEPS_DST: assert property (@(posedge clk) disable iff (!rst_n)
        rte_op |=> $stable(dst_idx)); // R3
    AST_OTHER_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && !sel_op && !rte_op) |=> $stable(dst_idx) && $stable(src_idx)); // R4
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !instr_valid |=> $stable(dst_idx) && $stable(src_idx)); // R5
    AST_DST_READ: assert property (@(posedge clk) disable iff (!rst_n)
        dst_data == rf_rdata[dst_idx*DATA_W +: DATA_W]); // R6
    AST_SRC_READ: assert property (@(posedge clk) disable iff (!rst_n)
        src_data == rf_rdata[src_idx*DATA_W +: DATA_W]); // R7
endmodule

bind opp_top opp_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .instr_valid (instr_valid),
    .opcode      (opcode),
    .rf_rdata    (rf_rdata),
    .dst_idx     (dst_idx),
    .src_idx     (src_idx),
    .dst_data    (dst_data),
    .src_data    (src_data)
);

// File: tb/tb_opp_top.sv
`timescale 1ns/1ps
module tb_opp_top;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         instr_valid = 1'b0;
    logic [7:0]   opcode = 8'h00;
    logic [127:0] rf_rdata = '0;
    logic [3:0]   dst_idx;
    logic [3:0]   src_idx;
    logic [7:0]   dst_data;
    logic [7:0]   src_data;

    int tests = 0;
    int fails = 0;
    int ref_dst = 0;
    int ref_src = 0;
    string last_tag = "R1";
    byte unsigned regs [16];

    always #2.5 clk = ~clk;

    opp_top dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .instr_valid (instr_valid),
        .opcode      (opcode),
        .rf_rdata    (rf_rdata),
        .dst_idx     (dst_idx),
        .src_idx     (src_idx),
        .dst_data    (dst_data),
        .src_data    (src_data)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic fill_regs();
        for (int k = 0; k < 16; k++) begin
            regs[k] = 8'($urandom);
            rf_rdata[k*8 +: 8] = regs[k];
        end
    endtask

    task automatic check_all();
        check(last_tag, "dst_idx", int'(dst_idx), ref_dst);
        check(last_tag, "src_idx", int'(src_idx), ref_src);
        check("R6", "dst_data", int'(dst_data), int'(regs[ref_dst]));
        check("R7", "src_data", int'(src_data), int'(regs[ref_src]));
    endtask

    // Drive at falling edge, check settled outputs, then let the rising edge act.
    task automatic step(input logic v, input logic [7:0] op);
        @(negedge clk);
        instr_valid = v;
        opcode = op;
        fill_regs();
        #1;
        check_all();
        @(posedge clk);
        if (!v) begin
            last_tag = "R5";
        end else if (op[7:4] == 4'hF) begin
            ref_dst = int'(op[3:0]);
            last_tag = "R2";
        end else if (op[7:4] == 4'hE) begin
            ref_src = int'(op[3:2]) * 4 + int'(op[1:0]);
            last_tag = "R3";
        end else begin
            last_tag = "R4";
        end
    endtask

    initial begin
        #100000;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        // R1: prefixes presented during reset must not load
        repeat (2) @(negedge clk);
        instr_valid = 1'b1;
        opcode = 8'hF7;
        fill_regs();
        #1;
        check_all();
        @(negedge clk);
        opcode = 8'hEB;
        #1;
        check_all();
        rst_n = 1'b1;
        instr_valid = 1'b0;
        step(1'b0, 8'h00);          // R1 first cycle after reset
        step(1'b1, 8'hF5);          // R2
        step(1'b1, 8'hE9);          // R3 group 2 member 1
        step(1'b1, 8'h35);          // R4
        step(1'b1, 8'hDF);          // R4 boundary
        step(1'b0, 8'hF3);          // R5 select ignored
        step(1'b0, 8'hE2);          // R5 route ignored
        step(1'b1, 8'hE0);          // R3 lowest
        step(1'b1, 8'hFF);          // R2 highest
        step(1'b1, 8'hEF);          // R3 highest
        step(1'b1, 8'hF0);          // R2 lowest
        step(1'b1, 8'h00);          // R4
        for (int i = 0; i < 400; i++) begin
            step(1'($urandom), 8'($urandom));
        end
        step(1'b0, 8'h00);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule